// File: doc/BRIEF.md
# Data Link Receive FIFO Controller

This block sits between a serial data-link receiver and a processor. The receiver pushes bytes into a 64-entry FIFO. Each byte carries a tag that marks the end of a message. The processor pulls bytes out through a registered read port. The block watches the fill level and the stored end-of-message tags, and raises three single-cycle events: full, near-full and message-available. Each event fires on the rising edge of its condition.

The meaning of the full event depends on the mode. In framed (HDLC) mode it reports an overrun, which is an attempt to write into a FIFO that is already full. In the two unformatted packing modes it reports that the fill has reached a programmable fill limit. The near-full event uses its own threshold. The message event fires when a tagged end of message is stored, or when the fill reaches the fill limit before any tag has arrived (a partial message). Deframing, bit destuffing and CRC checking are done upstream.

Top module: `dlrx_fifo_ctrl`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) empties the FIFO and clears the edge detectors. In the cycle after reset is released, all three event outputs are low.
- R2: Bytes come out in the order they were written, each with its own end-of-message tag. Read data and tag are registered and appear in the cycle after the clock edge that captured rd_en.
- R3: Mode encoding on cfg_mode is: 2'b00 framed (HDLC), 2'b01 six-bit packing, 2'b10 eight-bit packing, 2'b11 handled as framed. In six-bit packing mode a stored byte keeps wr_byte[5:0] and has bits 7:6 forced to zero. The other modes store all 8 bits.
- R4: A write into a FIFO holding 64 entries is dropped and leaves the stored contents unchanged. In framed mode the first such attempt makes ev_full high in the cycle after the edge that captured it.
- R5: In framed mode, back-to-back overrun attempts give a single ev_full pulse. A new pulse needs at least one cycle with no overrun attempt in between.
- R6: In the packing modes, ev_full pulses in the cycle after the fill level rises to at least cfg_fill_lim. A limit of 0 disables this event.
- R7: ev_near pulses in the cycle after the fill level rises to at least cfg_near_thr, with 0 disabling it. It fires again only after the fill has dropped below the threshold and then reached it again.
- R8: ev_msg pulses in the cycle after the first byte tagged as end of message is stored in a FIFO that held no tagged byte.
- R9: If the fill reaches cfg_fill_lim (non-zero) while no tagged byte is stored, this is a partial message and ev_msg pulses in the cycle after that write.
- R10: A read from an empty FIFO returns data 0 and tag 0 and moves no pointer. Later writes and reads behave normally.
- R11: Each event output is high for exactly one cycle per rising edge of its condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode | input | 2 | Operating mode (see R3) |
| cfg_near_thr | input | 7 | Near-full threshold, 0 disables |
| cfg_fill_lim | input | 7 | Message fill limit, 0 disables |
| wr_en | input | 1 | Write strobe from the receiver |
| wr_byte | input | 8 | Received byte |
| wr_eom | input | 1 | End-of-message tag for wr_byte |
| rd_en | input | 1 | Read strobe from the processor |
| rd_byte | output | 8 | Read data, registered |
| rd_eom | output | 1 | End-of-message tag of the read byte |
| ev_full | output | 1 | Overrun (framed) or fill-limit (packing) event |
| ev_near | output | 1 | Near-full event |
| ev_msg | output | 1 | Whole or partial message available event |

## Verification
Every result of this block is due exactly one clock edge after the edge that captures its stimulus. A write or overrun attempt shows up on an event output during the following cycle, and a read strobe shows up on rd_byte and rd_eom during the following cycle. The bench changes inputs on the falling edge, waits one falling edge, and then samples every output once. It also checks that a pulse is gone on the next sample, which covers single-cycle behaviour and the rule that repeated overrun attempts give one pulse.

// File: rtl/dlrx_pkg.sv
package dlrx_pkg;

  localparam int unsigned DL_BYTE_W = 8;

  typedef enum logic [1:0] {
    DL_FRAMED = 2'b00,
    DL_PACK6  = 2'b01,
    DL_PACK8  = 2'b10,
    DL_RSVD   = 2'b11
  } dl_mode_e;

  // Packing modes use the fill limit for the full event.
  function automatic logic mode_is_packed(input logic [1:0] m);
    return (m == DL_PACK6) || (m == DL_PACK8);
  endfunction

  // Six-bit packing keeps only the low six bits.
  function automatic logic [DL_BYTE_W-1:0] shape_byte(input logic [1:0] m,
                                                      input logic [DL_BYTE_W-1:0] d);
    if (m == DL_PACK6) return {2'b00, d[5:0]};
    return d;
  endfunction

endpackage

// File: rtl/dlrx_store.sv
module dlrx_store #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned W     = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_byte,
  input  logic          wr_eom,
  input  logic          rd_en,
  output logic [W-1:0]  rd_byte,
  output logic          rd_eom,
  output logic [CW-1:0] fill,
  output logic [CW-1:0] eom_fill,
  output logic          overrun_try
);

  logic [W:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          push, pop, pop_eom;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  function automatic logic [CW-1:0] level_next(input logic [CW-1:0] lv,
                                               input logic up, input logic dn);
    case ({up, dn})
      2'b10:   return lv + 1'b1;
      2'b01:   return lv - 1'b1;
      default: return lv;
    endcase
  endfunction

  // Event wires, named so the assertions can see them.
  assign overrun_try = wr_en && (fill == CW'(DEPTH));
  assign push        = wr_en && (fill != CW'(DEPTH));
  assign pop         = rd_en && (fill != '0);
  assign pop_eom     = pop && mem[rptr][W];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= {wr_eom, wr_byte};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      fill     <= '0;
      eom_fill <= '0;
      rd_byte  <= '0;
      rd_eom   <= 1'b0;
    end else begin
      if (push) wptr <= ptr_next(wptr);
      if (pop) begin
        rptr    <= ptr_next(rptr);
        rd_byte <= mem[rptr][W-1:0];
        rd_eom  <= mem[rptr][W];
      end else begin
        rd_byte <= '0;
        rd_eom  <= 1'b0;
      end
      fill     <= level_next(fill, push, pop);
      eom_fill <= level_next(eom_fill, push && wr_eom, pop_eom);
    end
  end

  // R4
  fill_cap_chk: assert property (@(posedge clk) disable iff (rst)
    fill <= CW'(DEPTH));

  // R4
  ovr_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (overrun_try && !rd_en) |=> (fill == CW'(DEPTH)) && $stable(wptr));

  // R10
  empty_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && fill == '0) |=> (rd_byte == '0) && !rd_eom && $stable(rptr));

  // R8
  eom_bound_chk: assert property (@(posedge clk) disable iff (rst)
    eom_fill <= fill);

endmodule

// File: rtl/dlrx_cond.sv
module dlrx_cond #(
  parameter int unsigned CW = 7
) (
  input  logic [1:0]    mode,
  input  logic [CW-1:0] fill,
  input  logic [CW-1:0] eom_fill,
  input  logic [CW-1:0] near_thr,
  input  logic [CW-1:0] fill_lim,
  input  logic          ovr_seen,
  output logic          full_lvl,
  output logic          near_lvl,
  output logic          msg_lvl
);
  import dlrx_pkg::*;

  // A zero threshold means "never".
  function automatic logic at_level(input logic [CW-1:0] lv, input logic [CW-1:0] thr);
    return (thr != '0) && (lv >= thr);
  endfunction

  logic lim_hit, partial_msg;

  assign lim_hit     = at_level(fill, fill_lim);
  assign partial_msg = lim_hit && (eom_fill == '0);
  assign full_lvl    = mode_is_packed(mode) ? lim_hit : ovr_seen;
  assign near_lvl    = at_level(fill, near_thr);
  assign msg_lvl     = (eom_fill != '0) || partial_msg;

endmodule

// File: rtl/dlrx_edge.sv
module dlrx_edge #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] pulse
);
  logic [N-1:0] lvl_q;

  for (genvar i = 0; i < N; i++) begin : g_det
    always_ff @(posedge clk) begin
      if (rst) lvl_q[i] <= 1'b0;
      else     lvl_q[i] <= lvl[i];
    end
    assign pulse[i] = lvl[i] && !lvl_q[i];

    // R11
    rise_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(lvl[i]) |-> pulse[i]);
  end

endmodule

// File: rtl/dlrx_fifo_ctrl.sv
module dlrx_fifo_ctrl #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned BW   = dlrx_pkg::DL_BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    cfg_mode,
  input  logic [CW-1:0] cfg_near_thr,
  input  logic [CW-1:0] cfg_fill_lim,
  input  logic          wr_en,
  input  logic [BW-1:0] wr_byte,
  input  logic          wr_eom,
  input  logic          rd_en,
  output logic [BW-1:0] rd_byte,
  output logic          rd_eom,
  output logic          ev_full,
  output logic          ev_near,
  output logic          ev_msg
);
  import dlrx_pkg::*;

  logic [CW-1:0] fill, eom_fill;
  logic          overrun_try, ovr_seen;
  logic          full_lvl, near_lvl, msg_lvl;
  logic [2:0]    ev_vec;

  dlrx_store #(.DEPTH(DEPTH), .W(BW)) store_i (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_byte(shape_byte(cfg_mode, wr_byte)), .wr_eom(wr_eom),
    .rd_en(rd_en), .rd_byte(rd_byte), .rd_eom(rd_eom),
    .fill(fill), .eom_fill(eom_fill), .overrun_try(overrun_try)
  );

  always_ff @(posedge clk) begin
    if (rst) ovr_seen <= 1'b0;
    else     ovr_seen <= overrun_try;
  end

  dlrx_cond #(.CW(CW)) cond_i (
    .mode(cfg_mode), .fill(fill), .eom_fill(eom_fill),
    .near_thr(cfg_near_thr), .fill_lim(cfg_fill_lim), .ovr_seen(ovr_seen),
    .full_lvl(full_lvl), .near_lvl(near_lvl), .msg_lvl(msg_lvl)
  );

  dlrx_edge #(.N(3)) edge_i (
    .clk(clk), .rst(rst),
    .lvl({msg_lvl, near_lvl, full_lvl}),
    .pulse(ev_vec)
  );

  assign ev_full = ev_vec[0];
  assign ev_near = ev_vec[1];
  assign ev_msg  = ev_vec[2];

  // R4
  framed_full_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_full && !mode_is_packed(cfg_mode)) |-> $past(wr_en));

  // R6
  packed_full_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_full && mode_is_packed(cfg_mode)) |-> (cfg_fill_lim != '0) && (fill >= cfg_fill_lim));

  // R11
  near_once_chk: assert property (@(posedge clk) disable iff (rst)
    ev_near |=> !ev_near);

endmodule

// File: tb/dlrx_fifo_ctrl_tb_top.sv
`timescale 1ns/1ps
module dlrx_fifo_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cfg_mode = 2'b10;
  logic [6:0] cfg_near_thr = '0, cfg_fill_lim = '0;
  logic       wr_en = 1'b0, wr_eom = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_byte = '0;
  logic [7:0] rd_byte;
  logic       rd_eom, ev_full, ev_near, ev_msg;

  int checks = 0, errors = 0;
  bit done = 0;
  logic s_full, s_near, s_msg, s_eom;
  logic [7:0] s_rd;

  always #4 clk = ~clk;

  dlrx_fifo_ctrl dut_i (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_near_thr(cfg_near_thr),
    .cfg_fill_lim(cfg_fill_lim), .wr_en(wr_en), .wr_byte(wr_byte), .wr_eom(wr_eom),
    .rd_en(rd_en), .rd_byte(rd_byte), .rd_eom(rd_eom),
    .ev_full(ev_full), .ev_near(ev_near), .ev_msg(ev_msg)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One cycle: drive at a falling edge, sample at the next falling edge.
  task automatic cyc(input logic we, input logic [7:0] d, input logic e, input logic re);
    wr_en = we; wr_byte = d; wr_eom = e; rd_en = re;
    @(negedge clk);
    s_full = ev_full; s_near = ev_near; s_msg = ev_msg; s_rd = rd_byte; s_eom = rd_eom;
    wr_en = 0; rd_en = 0; wr_eom = 0;
  endtask

  task automatic do_reset(input logic [1:0] m, input logic [6:0] thr, input logic [6:0] lim);
    cfg_mode = m; cfg_near_thr = thr; cfg_fill_lim = lim;
    rst = 1;
    cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    rst = 0;
    cyc(0, 0, 0, 0);
  endtask

  task automatic t_reset();
    do_reset(2'b10, 7'd0, 7'd0);
    chk("R1 ev_full", s_full, 0); chk("R1 ev_near", s_near, 0); chk("R1 ev_msg", s_msg, 0);
    cyc(0, 0, 0, 1);
    chk("R10 empty data", s_rd, 0); chk("R10 empty tag", s_eom, 0);
    cyc(1, 8'hAB, 1, 0);
    cyc(0, 0, 0, 1);
    chk("R10 later read", s_rd, 8'hAB); chk("R10 later tag", s_eom, 1);
  endtask

  task automatic t_order();
    do_reset(2'b10, 7'd0, 7'd0);
    for (int i = 0; i < 5; i++) begin
      cyc(1, 8'h10 + 8'(i), (i == 4), 0);
      chk("R8 msg on tagged write", s_msg, (i == 4));
    end
    for (int i = 0; i < 5; i++) begin
      cyc(0, 0, 0, 1);
      chk("R2 order data", s_rd, 8'h10 + i);
      chk("R2 order tag", s_eom, (i == 4));
    end
  endtask

  task automatic t_pack6();
    do_reset(2'b01, 7'd0, 7'd0);
    cyc(1, 8'hFF, 0, 0);
    cyc(0, 0, 0, 1);
    chk("R3 six-bit mask", s_rd, 8'h3F);
    cfg_mode = 2'b00;
    cyc(1, 8'hA5, 0, 0);
    cyc(0, 0, 0, 1);
    chk("R3 framed full byte", s_rd, 8'hA5);
  endtask

  task automatic t_near();
    do_reset(2'b10, 7'd3, 7'd0);
    cyc(1, 1, 0, 0); chk("R7 below thr", s_near, 0);
    cyc(1, 2, 0, 0); chk("R7 below thr", s_near, 0);
    cyc(1, 3, 0, 0); chk("R7 reach thr", s_near, 1);
    cyc(1, 4, 0, 0); chk("R11 near one cycle", s_near, 0);
    cyc(0, 0, 0, 1); chk("R7 still above", s_near, 0);
    cyc(0, 0, 0, 1);
    cyc(1, 5, 0, 0); chk("R7 re-reach", s_near, 1);
    chk("R6 lim 0 disabled", s_full, 0);
  endtask

  task automatic t_limit();
    do_reset(2'b10, 7'd0, 7'd4);
    for (int i = 0; i < 4; i++) begin
      cyc(1, 8'(i), 0, 0);
      chk("R6 fill limit full", s_full, (i == 3));
      chk("R9 partial msg", s_msg, (i == 3));
    end
    cyc(1, 8'h44, 0, 0);
    chk("R11 full one cycle", s_full, 0);
  endtask

  task automatic t_overrun();
    do_reset(2'b00, 7'd0, 7'd0);
    for (int i = 0; i < 64; i++) cyc(1, 8'(i), 0, 0);
    chk("R4 no event at 64", s_full, 0);
    cyc(1, 8'hEE, 0, 0); chk("R4 overrun event", s_full, 1);
    cyc(1, 8'hEE, 0, 0); chk("R5 repeat no pulse", s_full, 0);
    cyc(0, 0, 0, 0);
    cyc(1, 8'hEE, 0, 0); chk("R5 pulse after gap", s_full, 1);
    for (int i = 0; i < 64; i++) begin
      cyc(0, 0, 0, 1);
      chk("R4 contents intact", s_rd, i);
    end
    cyc(0, 0, 0, 1);
    chk("R10 drained read", s_rd, 0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_order();
    t_pack6();
    t_near();
    t_limit();
    t_overrun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule